// File: doc/BRIEF.md
# Modulus Counter Timer Channel

This block is one timer channel run as a modulus counter. A counter of `WIDTH` bits (24 by default) steps on count events until it equals the programmed limit register. It can serve as a shared time base on a count bus, or as a general-purpose periodic timer. In up-only operation, reaching the limit clears the counter and raises a sticky flag. In up/down operation, the counter turns around at the limit and again at zero, which gives a triangular sequence. The flag is raised only at the limit.

Count events come from one of two sources, chosen by a configuration bit. The first is an internal prescaled tick. The second is a transition of an external, already filtered input, and that transition can be the rising edge, the falling edge or either edge. The counter is cleared in the clock cycle that directly follows the one in which it shows the limit value, without waiting for another count event. With a slow external source the zero state is therefore shorter than one input period. Software clears the flag by writing one to a clear strobe.

Top module: `modcnt_chan`

## Requirements
- R1: After reset the count is 0, the flag is 0, the direction output is 0, the limit register holds all ones, and the configuration selects the internal tick, up-only counting, single-edge mode and rising polarity.
- R2: With the internal source selected (`cfg_ext_clk`=0), each cycle with `tick_int`=1 is a count event and a cycle with `tick_int`=0 leaves the count unchanged. `ext_in` has no effect.
- R3: With the external source selected (`cfg_ext_clk`=1), a count event is a change of `ext_in` against its value in the previous cycle. If `cfg_edge_both`=1, either direction counts. Otherwise `cfg_edge_rise`=1 selects 0→1 and `cfg_edge_rise`=0 selects 1→0. `tick_int` has no effect.
- R4: In up-only mode (`cfg_up_down`=0), a cycle in which the count equals the limit is followed by count 0 and flag 1 on the next clock edge. A count event in that cycle is not applied.
- R5: After a clear the count stays 0 until the next count event, which makes it 1.
- R6: If the limit is written below the current count, the counter keeps counting up, wraps from all ones to 0, and clears when it next equals the limit.
- R7: In up/down mode, a cycle in which the count equals the limit while counting up is followed by `dir_down`=1 and flag 1, with the count held. Later count events decrement the count.
- R8: In up/down mode, a cycle with count 0 while counting down is followed by `dir_down`=0, with the count held and no flag set. Later events increment the count.
- R9: The flag stays 1 until a cycle with `flag_clr`=1, and it reads 0 after that cycle unless a match occurred in it.
- R10: A match in the same cycle as `flag_clr`=1 leaves the flag at 1.
- R11: `dir_down` is 0 in every cycle in which up-only mode is configured. A configuration write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal prescaled count tick |
| ext_in | input | 1 | Filtered external count input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ext_clk | input | 1 | 1 = external input is the count source |
| cfg_up_down | input | 1 | 1 = up/down counting, 0 = up only |
| cfg_edge_both | input | 1 | 1 = count on both external edges |
| cfg_edge_rise | input | 1 | Single-edge polarity: 1 rising, 0 falling |
| a1_we | input | 1 | Limit register write strobe |
| a1_wdata | input | WIDTH | Limit value to write |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cnt_bus | output | WIDTH | Current count, driven onto the count bus |
| dir_down | output | 1 | 1 while counting down in up/down mode |
| flag | output | 1 | Sticky match flag |

## Verification
A limit match and a software flag clear can occur in the same cycle. The match must win, so the flag stays set. The bench provokes this by holding `flag_clr` high while the internal tick drives the counter to a small limit on every cycle. It also asserts the clear at random in the random phases. A second collision is a count event that arrives in the match cycle. The bench compares every cycle against a model built from the requirements, so a misapplied event shows up as a count that is off by one after the clear or turn-around.

// File: rtl/mc_pkg.sv
package mc_pkg;

   // Channel configuration captured on a configuration write
   typedef struct packed {
      logic ext_clk;    // 1: external input supplies count events
      logic up_down;    // 1: triangular up/down counting
      logic edge_both;  // 1: both external transitions count
      logic edge_rise;  // single-edge polarity, 1 = rising
   } mc_cfg_t;

   localparam mc_cfg_t MC_CFG_RESET = '{ext_clk: 1'b0, up_down: 1'b0,
                                        edge_both: 1'b0, edge_rise: 1'b1};

endpackage

// File: rtl/mc_event_sel.sv
module mc_event_sel
   import mc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  mc_cfg_t cfg,
   input  logic    tick_int,
   input  logic    ext_in,
   output logic    count_ev
);

   logic prev_q;
   logic rise, fall, ext_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= ext_in;
   end

   assign rise = ext_in & ~prev_q;
   assign fall = ~ext_in & prev_q;

   always_comb begin
      if (cfg.edge_both)      ext_ev = rise | fall;
      else if (cfg.edge_rise) ext_ev = rise;
      else                    ext_ev = fall;
   end

   assign count_ev = cfg.ext_clk ? ext_ev : tick_int;

endmodule

// File: rtl/mc_count_core.sv
module mc_count_core #(
   parameter int unsigned WIDTH     = 24,
   parameter bit          UPDOWN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_ev,
   input  logic             up_down,
   input  logic [WIDTH-1:0] limit,
   output logic [WIDTH-1:0] cnt,
   output logic             dir_down,
   output logic             hit
);

   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] ZERO = '0;

   logic [WIDTH-1:0] cnt_q, cnt_d;
   logic             dir_q, dir_d;
   logic             ud_eff;
   logic             at_top, at_zero;

   generate
      if (UPDOWN_EN) begin : g_ud
         assign ud_eff = up_down;
      end else begin : g_up_only
         assign ud_eff = 1'b0;
      end
   endgenerate

   assign at_top  = (cnt_q == limit);
   assign at_zero = (cnt_q == ZERO);

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      hit   = 1'b0;
      if (!ud_eff) begin
         dir_d = 1'b0;
         if (at_top) begin
            cnt_d = ZERO;
            hit   = 1'b1;
         end else if (count_ev) begin
            cnt_d = cnt_q + ONE;
         end
      end else if (!dir_q && at_top) begin
         dir_d = 1'b1;
         hit   = 1'b1;
      end else if (dir_q && at_zero) begin
         dir_d = 1'b0;
      end else if (count_ev) begin
         cnt_d = dir_q ? (cnt_q - ONE) : (cnt_q + ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         dir_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign cnt      = cnt_q;
   assign dir_down = dir_q & ud_eff;

endmodule

// File: rtl/mc_flag.sv
module mc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= hit | (flag_q & ~clr);
   end

   assign flag = flag_q;

endmodule

// File: rtl/modcnt_chan.sv
module modcnt_chan
   import mc_pkg::*;
#(
   parameter int unsigned WIDTH     = 24,
   parameter bit          UPDOWN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_int,
   input  logic             ext_in,
   input  logic             cfg_we,
   input  logic             cfg_ext_clk,
   input  logic             cfg_up_down,
   input  logic             cfg_edge_both,
   input  logic             cfg_edge_rise,
   input  logic             a1_we,
   input  logic [WIDTH-1:0] a1_wdata,
   input  logic             flag_clr,
   output logic [WIDTH-1:0] cnt_bus,
   output logic             dir_down,
   output logic             flag
);

   localparam logic [WIDTH-1:0] LIMIT_RESET = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("modcnt_chan: WIDTH must lie in 2..32");
      end
   endgenerate

   mc_cfg_t          cfg_q;
   logic [WIDTH-1:0] a1_q;
   logic             count_ev;
   logic             hit;
   logic             up_down_q;
   logic             ext_clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= MC_CFG_RESET;
         a1_q  <= LIMIT_RESET;
      end else begin
         if (cfg_we)
            cfg_q <= '{ext_clk: cfg_ext_clk, up_down: cfg_up_down,
                       edge_both: cfg_edge_both, edge_rise: cfg_edge_rise};
         if (a1_we)
            a1_q <= a1_wdata;
      end
   end

   assign up_down_q = cfg_q.up_down;
   assign ext_clk_q = cfg_q.ext_clk;

   mc_event_sel u_evsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q),
      .tick_int (tick_int),
      .ext_in   (ext_in),
      .count_ev (count_ev)
   );

   mc_count_core #(.WIDTH(WIDTH), .UPDOWN_EN(UPDOWN_EN)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_ev (count_ev),
      .up_down  (up_down_q),
      .limit    (a1_q),
      .cnt      (cnt_bus),
      .dir_down (dir_down),
      .hit      (hit)
   );

   mc_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .clr   (flag_clr),
      .flag  (flag)
   );

endmodule

// File: rtl/mc_chk.sv
module mc_chk #(
   parameter int unsigned WIDTH = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] cnt,
   input logic [WIDTH-1:0] a1,
   input logic             up_down,
   input logic             ext_clk,
   input logic             tick_int,
   input logic             cfg_we,
   input logic             hit,
   input logic             flag_clr,
   input logic             flag,
   input logic             dir_down
);

   // R2
   int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_clk && !up_down && !tick_int && cnt != a1) |=> $stable(cnt));

   // R4
   up_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_down && cnt == a1) |=> (cnt == '0 && flag));

   // R7
   turn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_down && !cfg_we && !dir_down && cnt == a1) |=> (dir_down && flag && $stable(cnt)));

   // R8
   turn_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_down && !cfg_we && dir_down && cnt == '0) |=> (!dir_down && cnt == '0));

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

   // R10
   clr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && flag_clr) |=> flag);

   // R11
   up_only_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !up_down |-> !dir_down);

endmodule

bind modcnt_chan mc_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (cnt_bus),
   .a1       (a1_q),
   .up_down  (up_down_q),
   .ext_clk  (ext_clk_q),
   .tick_int (tick_int),
   .cfg_we   (cfg_we),
   .hit      (hit),
   .flag_clr (flag_clr),
   .flag     (flag),
   .dir_down (dir_down)
);

// File: tb/modcnt_chan_bench.sv
`timescale 1ns/1ps
module modcnt_chan_bench;

   localparam int W = 8;
   localparam int MAX_CYC = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_int = 1'b0, ext_in = 1'b0;
   logic         cfg_we = 1'b0, cfg_ext_clk = 1'b0, cfg_up_down = 1'b0;
   logic         cfg_edge_both = 1'b0, cfg_edge_rise = 1'b1;
   logic         a1_we = 1'b0, flag_clr = 1'b0;
   logic [W-1:0] a1_wdata = '0;
   logic [W-1:0] cnt_bus;
   logic         dir_down, flag;

   int n_run = 0, n_fail = 0;
   string tag = "R1";
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   modcnt_chan #(.WIDTH(W)) u_modcnt_chan (
      .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .ext_in(ext_in),
      .cfg_we(cfg_we), .cfg_ext_clk(cfg_ext_clk), .cfg_up_down(cfg_up_down),
      .cfg_edge_both(cfg_edge_both), .cfg_edge_rise(cfg_edge_rise),
      .a1_we(a1_we), .a1_wdata(a1_wdata), .flag_clr(flag_clr),
      .cnt_bus(cnt_bus), .dir_down(dir_down), .flag(flag)
   );

   // Reference model derived from the requirements
   logic [W-1:0] m_cnt, m_a1;
   logic m_dir, m_flag, m_pv, m_ext, m_ud, m_both, m_rise;

   function automatic logic qual_event(logic ext, logic pv, logic tick,
                                       logic sel_ext, logic both, logic rise);
      logic r, f;
      r = ext & ~pv;
      f = ~ext & pv;
      if (!sel_ext) return tick;
      if (both) return r | f;
      return rise ? r : f;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= '0; m_a1 <= '1; m_dir <= 1'b0; m_flag <= 1'b0; m_pv <= 1'b0;
         m_ext <= 1'b0; m_ud <= 1'b0; m_both <= 1'b0; m_rise <= 1'b1;
      end else begin
         logic ev, hitv, nd;
         logic [W-1:0] nc;
         ev = qual_event(ext_in, m_pv, tick_int, m_ext, m_both, m_rise);
         hitv = 1'b0; nc = m_cnt; nd = m_dir;
         if (!m_ud) begin
            nd = 1'b0;
            if (m_cnt == m_a1) begin nc = '0; hitv = 1'b1; end
            else if (ev) nc = m_cnt + 1'b1;
         end else if (!m_dir && m_cnt == m_a1) begin
            nd = 1'b1; hitv = 1'b1;
         end else if (m_dir && m_cnt == '0) begin
            nd = 1'b0;
         end else if (ev) begin
            nc = m_dir ? m_cnt - 1'b1 : m_cnt + 1'b1;
         end
         m_cnt  <= nc;
         m_dir  <= nd;
         m_flag <= hitv | (m_flag & ~flag_clr);
         m_pv   <= ext_in;
         if (cfg_we) begin
            m_ext <= cfg_ext_clk; m_ud <= cfg_up_down;
            m_both <= cfg_edge_both; m_rise <= cfg_edge_rise;
         end
         if (a1_we) m_a1 <= a1_wdata;
      end
   end

   task automatic check(string t, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual %0d expected %0d", t, what, act, exp);
      end
   endtask

   task automatic compare_model();
      check(tag, "cnt_bus", int'(cnt_bus), int'(m_cnt));
      check(tag, "flag", int'(flag), int'(m_flag));
      check(tag, "dir_down", int'(dir_down), int'(m_dir & m_ud));
   endtask

   // One clock: inputs already set, sample at the falling edge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      compare_model();
      cfg_we = 1'b0; a1_we = 1'b0;
   endtask

   task automatic write_cfg(logic e, logic ud, logic b, logic r);
      cfg_we = 1'b1; cfg_ext_clk = e; cfg_up_down = ud;
      cfg_edge_both = b; cfg_edge_rise = r;
      cyc();
   endtask

   task automatic write_a1(logic [W-1:0] v);
      a1_we = 1'b1; a1_wdata = v;
      cyc();
   endtask

   task automatic random_run(int n, int tick_pct, int tog_pct, int clr_pct, int cfg_pct);
      for (int i = 0; i < n; i++) begin
         tick_int = ($urandom_range(99) < tick_pct);
         if ($urandom_range(99) < tog_pct) ext_in = ~ext_in;
         flag_clr = ($urandom_range(99) < clr_pct);
         if ($urandom_range(999) < cfg_pct) begin
            cfg_we = 1'b1;
            cfg_ext_clk = 1'($urandom_range(1)); cfg_up_down = 1'($urandom_range(1));
            cfg_edge_both = 1'($urandom_range(1)); cfg_edge_rise = 1'($urandom_range(1));
         end
         if ($urandom_range(999) < cfg_pct) begin
            a1_we = 1'b1; a1_wdata = W'($urandom_range(2, 30));
         end
         cyc();
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      tag = "R1";
      check("R1", "reset cnt", int'(cnt_bus), 0);
      check("R1", "reset flag", int'(flag), 0);
      check("R1", "reset dir", int'(dir_down), 0);

      // R1/R4: reset limit is all ones; steady ticks reach it and clear
      tag = "R4";
      tick_int = 1'b1;
      for (int i = 0; i < 255; i++) cyc();
      check("R1", "cnt at reset limit", int'(cnt_bus), 255);
      check("R4", "flag before clear", int'(flag), 0);
      cyc();
      check("R4", "cnt after match", int'(cnt_bus), 0);
      check("R4", "flag after match", int'(flag), 1);
      // R5: zero held without events, then steps to 1
      tag = "R5";
      tick_int = 1'b0;
      cyc(); cyc();
      check("R5", "zero held", int'(cnt_bus), 0);
      tick_int = 1'b1;
      cyc();
      check("R5", "first step", int'(cnt_bus), 1);
      // R9: flag sticky, then cleared
      tag = "R9";
      tick_int = 1'b0;
      cyc();
      check("R9", "flag sticky", int'(flag), 1);
      flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
      check("R9", "flag cleared", int'(flag), 0);

      // R10: clear held high while matching a small limit on every tick
      tag = "R10";
      write_a1(8'd3);
      tick_int = 1'b1; flag_clr = 1'b1;
      for (int i = 0; i < 12; i++) begin
         cyc();
         if (cnt_bus == 0) check("R10", "flag after clear collision", int'(flag), 1);
      end
      flag_clr = 1'b0;

      // R2: internal source, random ticks, ext_in toggling ignored
      tag = "R2";
      write_a1(8'd9);
      random_run(400, 50, 40, 10, 0);

      // R3: external source, each edge mode
      tag = "R3";
      write_cfg(1'b1, 1'b0, 1'b0, 1'b1); random_run(300, 50, 35, 10, 0);
      write_cfg(1'b1, 1'b0, 1'b0, 1'b0); random_run(300, 50, 35, 10, 0);
      write_cfg(1'b1, 1'b0, 1'b1, 1'b0); random_run(300, 50, 35, 10, 0);

      // R5: slow external edges, shortened zero state
      tag = "R5";
      write_a1(8'd4);
      for (int i = 0; i < 240; i++) begin
         if (i % 6 == 0) ext_in = ~ext_in;
         flag_clr = 1'b0;
         cyc();
      end

      // R6: limit written below the current count wraps through all ones
      tag = "R6";
      write_cfg(1'b0, 1'b0, 1'b0, 1'b1);
      write_a1(8'd200);
      tick_int = 1'b1;
      for (int i = 0; i < 100; i++) cyc();
      write_a1(8'd10);
      for (int i = 0; i < 400; i++) cyc();

      // R7 and R8: up/down counting, internal then both-edge external
      tag = "R7";
      write_cfg(1'b0, 1'b1, 1'b0, 1'b1);
      write_a1(8'd12);
      random_run(500, 60, 30, 10, 0);
      tag = "R8";
      write_cfg(1'b1, 1'b1, 1'b1, 1'b1);
      random_run(500, 50, 40, 10, 0);

      // R11: random configuration and limit rewrites mixed with everything
      tag = "R11";
      for (int k = 0; k < 10; k++) random_run(1000, 50, 30, 8, 15);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule